// File: doc/BRIEF.md
# General-Purpose I/O Port with Direction-Aware Readback

This block is one parallel I/O port on a small processor bus. Each pin has six configuration bits: an output latch, a direction bit, a pull-up request, a slew-rate limit, a drive-strength select and an analog-function select. The CPU reaches these bits through a simple register write/read interface. The pad ring receives an output enable, an output value and the per-pin control levels from the block. It returns the raw input level of each pad.

A read of the data register gives a different source for each pin. An output pin returns its own latch. An input pin returns its pad level after a two-flop synchronizer. An input pin assigned to an analog function returns 0. Because of this, a bit-set or bit-clear done as read-modify-write on one pin can never copy a foreign pad level into the latch of another output pin. The latch takes writes in either direction, so software can preload a level before it turns a pin into an output.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0. Every pin is then an input: pad_oe = 0, pad_pullup = 0, pad_slew = 0, pad_drive = 0 and pad_analog = 0.
- R2: For a pin with direction 0 and analog select 0, bit i of a data-register read (offset 0) equals pad_in[i] as sampled two rising edges earlier. A pad change is therefore invisible after one edge and visible after two.
- R3: For a pin with direction 1, bit i of a data-register read returns the output latch, whatever the pad level.
- R4: pad_oe[i] equals the direction bit (offset 1). pad_out[i] equals the latch bit. Both change on the edge that takes the write.
- R5: A write to offset 0 updates the latch of every pin, including input pins. A level written while a pin is an input shows on pad_out and in readback once its direction bit is set.
- R6: pad_pullup[i] is 1 only when the pull-up bit (offset 2) is 1, the pin is an input and its analog select is 0.
- R7: pad_slew mirrors offset 3 and pad_drive mirrors offset 4. Each changes on the edge that takes the write.
- R8: For a pin with direction 0 and analog select 1 (offset 5), bit i of a data-register read is 0 whatever the pad level. pad_analog mirrors offset 5.
- R9: Offsets 1 to 5 read back the value last written to them. Offsets 6 and 7 read 0, and writes to them change no register and no pad output.
- R10: Take a read of offset 0, OR one output pin's bit into it, and write the result back. Every other output pin keeps its latch, even when its pad is held at the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | 3 | Register offset: 0 data, 1 direction, 2 pull-up, 3 slew, 4 drive, 5 analog |
| wdata | input | N | Write data |
| rdata | output | N | Combinational read data for addr |
| pad_in | input | N | Raw pad input levels, asynchronous |
| pad_oe | output | N | Pad output-driver enable |
| pad_out | output | N | Pad output value |
| pad_pullup | output | N | Pull-up enable sent to the pad |
| pad_slew | output | N | Slew-rate limit enable |
| pad_drive | output | N | High drive-strength select |
| pad_analog | output | N | Analog-function select; also gates the digital input |

## Verification
The hard case to reach is an output pin whose pad is driven to the opposite of its latch while software does a read-modify-write on a different pin. That case only matters if the readback path is wrong. The bench builds it directly: it drives pad_in against the latch of an output pin and holds it there for the whole sequence. It then reads the data register, ORs in the bit of another output pin, writes the result back, and checks the first pin's latch on pad_out. Random rounds mix direction, analog and pad patterns. The two-edge lag of the synchronizer is checked edge by edge in a directed step.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;
    localparam int NUM_REGS = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 3'd0,
        REG_DIR   = 3'd1,
        REG_PULL  = 3'd2,
        REG_SLEW  = 3'd3,
        REG_DRIVE = 3'd4,
        REG_ANA   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      latch_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      pull_q,
    output logic [N-1:0]      slew_q,
    output logic [N-1:0]      drive_q,
    output logic [N-1:0]      ana_q
);
    logic [N-1:0] bank_q [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_q[r] <= '0;
                end else if (wr_en && (addr == ADDR_W'(r))) begin
                    bank_q[r] <= wdata;
                end
            end
        end
    endgenerate

    assign latch_q = bank_q[REG_DATA];
    assign dir_q   = bank_q[REG_DIR];
    assign pull_q  = bank_q[REG_PULL];
    assign slew_q  = bank_q[REG_SLEW];
    assign drive_q = bank_q[REG_DRIVE];
    assign ana_q   = bank_q[REG_ANA];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      latch_q,
    input  logic [N-1:0]      dir_q,
    input  logic [N-1:0]      pull_q,
    input  logic [N-1:0]      slew_q,
    input  logic [N-1:0]      drive_q,
    input  logic [N-1:0]      ana_q,
    input  logic [N-1:0]      pin_sync,
    output logic [N-1:0]      rdata
);
    logic [N-1:0] data_view;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            always_comb begin
                if (dir_q[i]) begin
                    data_view[i] = latch_q[i];
                end else if (ana_q[i]) begin
                    data_view[i] = 1'b0;
                end else begin
                    data_view[i] = pin_sync[i];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (addr)
            REG_DATA:  rdata = data_view;
            REG_DIR:   rdata = dir_q;
            REG_PULL:  rdata = pull_q;
            REG_SLEW:  rdata = slew_q;
            REG_DRIVE: rdata = drive_q;
            REG_ANA:   rdata = ana_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_pullup,
    output logic [N-1:0]      pad_slew,
    output logic [N-1:0]      pad_drive,
    output logic [N-1:0]      pad_analog
);
    logic [N-1:0] latch_q, dir_q, pull_q, slew_q, drive_q, ana_q;
    logic [N-1:0] pin_sync;

    gpio_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .slew_q  (slew_q),
        .drive_q (drive_q),
        .ana_q   (ana_q)
    );

    gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_readmux #(.N(N)) u_rmux (
        .addr     (addr),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .slew_q   (slew_q),
        .drive_q  (drive_q),
        .ana_q    (ana_q),
        .pin_sync (pin_sync),
        .rdata    (rdata)
    );

    assign pad_oe     = dir_q;
    assign pad_out    = latch_q;
    assign pad_pullup = pull_q & ~dir_q & ~ana_q;
    assign pad_slew   = slew_q;
    assign pad_drive  = drive_q;
    assign pad_analog = ana_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      rdata,
    input logic [N-1:0]      pad_in,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_pullup,
    input logic [N-1:0]      pad_slew,
    input logic [N-1:0]      pad_drive,
    input logic [N-1:0]      pad_analog
);
    // R2
    input_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_DATA) |->
            (((rdata ^ $past(pad_in, 2)) & ~pad_oe & ~pad_analog) == '0));

    // R3
    output_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_DATA) |-> ((rdata & pad_oe) == (pad_out & pad_oe)));

    // R8
    analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_DATA) |-> ((rdata & pad_analog & ~pad_oe) == '0));

    // R6
    pullup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pullup & (pad_oe | pad_analog)) == '0));

    // R5
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DATA) |=> (pad_out == $past(wdata)));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> (pad_oe == $past(wdata)));

    // R7
    slew_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_SLEW) |=> (pad_slew == $past(wdata)));

    // R7
    drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DRIVE) |=> (pad_drive == $past(wdata)));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > REG_ANA) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(pad_slew) &&
             $stable(pad_drive) && $stable(pad_analog) && $stable(pad_pullup)));
endmodule

bind gpio_port gpio_port_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pullup (pad_pullup),
    .pad_slew   (pad_slew),
    .pad_drive  (pad_drive),
    .pad_analog (pad_analog)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_oe, pad_out, pad_pullup, pad_slew, pad_drive, pad_analog;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] mdl [8];

    always #10 clk = ~clk;

    gpio_port #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pullup(pad_pullup), .pad_slew(pad_slew), .pad_drive(pad_drive),
        .pad_analog(pad_analog)
    );

    function automatic logic [N-1:0] exp_read(input int a, input logic [N-1:0] pad);
        if (a == 0) return (mdl[1] & mdl[0]) | (~mdl[1] & ~mdl[5] & pad);
        if (a >= 1 && a <= 5) return mdl[a];
        return '0;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        if (a <= 5) mdl[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [N-1:0] d);
        addr = 3'(a);
        #1;
        d = rdata;
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_oe"}, pad_oe, mdl[1]);
        check({req, " pad_out"}, pad_out, mdl[0]);
        check({req, " pad_pullup"}, pad_pullup, mdl[2] & ~mdl[1] & ~mdl[5]);
        check({req, " pad_slew"}, pad_slew, mdl[3]);
        check({req, " pad_drive"}, pad_drive, mdl[4]);
        check({req, " pad_analog"}, pad_analog, mdl[5]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1234));
        for (int k = 0; k < 8; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 1; a <= 5; a++) begin
            rd(a, v); check("R1 reset reg", v, '0);
        end
        check_pads("R1");

        // R2 two-edge lag on input pins
        pad_in = 8'hFF;
        addr = 3'd0;
        @(posedge clk); @(negedge clk);
        rd(0, v); check("R2 one edge", v, 8'h00);
        @(posedge clk); @(negedge clk);
        rd(0, v); check("R2 two edges", v, 8'hFF);

        // R5 latch written while input, appears after direction set
        wr(0, 8'hA5);
        rd(0, v); check("R5 input still reads pad", v, 8'hFF);
        check("R5 pad_out preload", pad_out, 8'hA5);
        wr(1, 8'hFF);
        rd(0, v); check("R5/R3 latch after dir set", v, 8'hA5);
        check_pads("R4");

        // R3 output pins ignore pad
        pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        rd(0, v); check("R3 output readback", v, 8'hA5);

        // R8 analog input reads 0, R6 pullup gating
        wr(1, 8'h00);
        wr(2, 8'hFF);
        wr(5, 8'h0F);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        rd(0, v); check("R8 analog reads 0", v, 8'hF0);
        check("R6 pullup gated", pad_pullup, 8'hF0);
        check("R8 pad_analog", pad_analog, 8'h0F);

        // R9 unmapped offsets
        wr(6, 8'hFF);
        wr(7, 8'h3C);
        rd(6, v); check("R9 offset 6", v, 8'h00);
        rd(7, v); check("R9 offset 7", v, 8'h00);
        check_pads("R9");

        // R10 read-modify-write bit set with opposing pad
        wr(5, 8'h00);
        wr(1, 8'h03);
        wr(0, 8'h00);
        pad_in = 8'h02;
        repeat (3) @(negedge clk);
        rd(0, v); check("R10 read ignores pad on output", v, 8'h00);
        wr(0, v | 8'h01);
        check("R10 other latch kept", pad_out[1], 1'b0);
        check("R10 bit set", pad_out[0], 1'b1);

        // R7 and random rounds
        for (int it = 0; it < 150; it++) begin
            int a = int'($urandom_range(0, 7));
            wr(a, N'($urandom));
            pad_in = N'($urandom);
            repeat (3) @(negedge clk);
            for (int r = 0; r < 8; r++) begin
                rd(r, v); check("R2/R3/R8/R9 random read", v, exp_read(r, pad_in));
            end
            check_pads("R4/R6/R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule